// File: doc/BRIEF.md
# Instrument Bus Port Register Block

This block connects a processor's register bus to a 16-line parallel instrument bus: eight data lines and eight control lines. Every line is open-collector and active-low. The block never drives a line high. It either pulls the line low or releases it. There is no direction register. Each line the processor controls has one bit in an output register and one bit in an input register. The input side always shows the line as it really is, which is the wired-AND of the block's own pull and any pull from other devices on the bus. Because of this, software can test the drivers and receivers by writing a value and reading it back.

All register bits use positive logic: a 1 means the line is asserted (electrically low). Two control lines, attention and service request, are captured on their false-to-true edge. They stay captured until software clears them. The service-request line is an input only. The end-of-message output bit also blanks the display. The interface-clear line is pulled only while the block is in reset. The remote-enable line is pulled at all times, so the port is the fixed system controller.

Bit positions in both control registers: 0 data-valid, 1 not-ready-for-data, 2 not-data-accepted, 3 attention, 4 service request, 5 interface clear, 6 remote enable, 7 end-of-message. Register addresses: 0 data output, 1 control output, 2 data input, 3 control input.

Top module: `gpib_port_regs`

## Requirements
- R1: During reset and after it, both output registers read 0, no data line is pulled, the display-blank output is 0, and both edge latches read 0 at address 3.
- R2: Address 0 is read/write. A 1 in bit n pulls data line n low on the clock edge that takes the write.
- R3: At address 1, only bits 0, 1, 2, 3 and 7 can be written, and each pulls its control line. Bits 4, 5 and 6 always read 0 and ignore writes.
- R4: Address 2 bit n reads 1 when data line n is low, whether the block or another device pulls it. The value passes through a two-flop synchronizer, so it is valid two clock edges after the pin changes.
- R5: At address 3, bits 0, 1, 2 and 7 are synchronized levels (1 means the line is low). Bits 5 and 6 always read 0.
- R6: Address 3 bits 3 and 4 are set on a synchronized high-to-low transition of the attention line and the service-request line. They hold until a write to address 3 with a 1 in that bit clears them. A write of 0 has no effect.
- R7: When the block's own attention output bit goes from 0 to 1, the attention latch is set.
- R8: If a clear and a new falling edge arrive in the same cycle, the latch stays set.
- R9: The display-blank output equals the end-of-message bit of the output register. Another device pulling the end-of-message line does not blank the display.
- R10: The interface-clear line is pulled exactly while reset is asserted. The remote-enable line is pulled at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| data_pin | input | 8 | Sensed data line levels (0 = low) |
| data_pull | output | 8 | 1 = pull data line low |
| ctl_pin | input | 8 | Sensed control line levels (0 = low) |
| ctl_pull | output | 8 | 1 = pull control line low |
| blank_out | output | 1 | Display blank request |

## Verification
The data read-back is tried three ways: with only the block's own pull, with only an external pull, and with both overlapping. This shows that the input register follows the wire and not the output register. The edge latches are driven by an external pull, by the block's own attention bit, and by a clear that lands in the same cycle as a fresh edge. This separates a correct set-dominant latch from a level copy and from a clear-dominant latch. An external end-of-message pull is applied on its own to show that display blanking follows only the output register.

// File: rtl/gpib_port_pkg.sv
package gpib_port_pkg;
  localparam int CTL_W        = 8;
  localparam int B_DVALID     = 0;
  localparam int B_NREADY     = 1;
  localparam int B_NACCEPT    = 2;
  localparam int B_ATTN       = 3;
  localparam int B_SVCREQ     = 4;
  localparam int B_IFCLR      = 5;
  localparam int B_REMOTE     = 6;
  localparam int B_ENDMSG     = 7;
  localparam int N_LATCH      = 2;

  localparam logic [CTL_W-1:0] COUT_WMASK = 8'b1000_1111;
  localparam logic [CTL_W-1:0] LEVEL_MASK = 8'b1000_0111;

  typedef enum logic [1:0] {
    A_DOUT = 2'd0,
    A_COUT = 2'd1,
    A_DIN  = 2'd2,
    A_CIN  = 2'd3
  } reg_addr_e;

  // active-low pin level to positive-logic "asserted"
  function automatic logic [CTL_W-1:0] ctl_asserted(input logic [CTL_W-1:0] lvl);
    return ~lvl;
  endfunction

  // latch next state: a fresh edge dominates a clear
  function automatic logic latch_next(input logic q, input logic fall, input logic clr);
    return fall | (q & ~clr);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] pin_lvl
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= pin_raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign pin_lvl = stg[STAGES-1];
endmodule

// File: rtl/fall_latch.sv
module fall_latch
  import gpib_port_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] clr,
  output logic [W-1:0] fall_evt,
  output logic [W-1:0] hold_q
);
  logic [W-1:0] prev_q;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign fall_evt[k] = prev_q[k] & ~lvl[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[k] <= 1'b1;
        hold_q[k] <= 1'b0;
      end else begin
        prev_q[k] <= lvl[k];
        hold_q[k] <= latch_next(hold_q[k], fall_evt[k], clr[k]);
      end
    end
  end
endmodule

// File: rtl/port_regfile.sv
module port_regfile
  import gpib_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [DATA_W-1:0] dout_q,
  output logic [CTL_W-1:0]  cout_q
);
  localparam int DW_USE = (DATA_W < 8) ? DATA_W : 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      cout_q <= '0;
    end else if (wr) begin
      if (addr == A_DOUT) dout_q <= DATA_W'(wdata[DW_USE-1:0]);
      if (addr == A_COUT) cout_q <= wdata & COUT_WMASK;
    end
  end
endmodule

// File: rtl/gpib_port_regs.sv
module gpib_port_regs
  import gpib_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [DATA_W-1:0] data_pin,
  output logic [DATA_W-1:0] data_pull,
  input  logic [CTL_W-1:0]  ctl_pin,
  output logic [CTL_W-1:0]  ctl_pull,
  output logic              blank_out
);
  localparam int DW_RD = (DATA_W < 8) ? DATA_W : 8;

  logic [DATA_W-1:0]  dout_q;
  logic [CTL_W-1:0]   cout_q;
  logic [DATA_W-1:0]  data_lvl;
  logic [CTL_W-1:0]   ctl_lvl;
  logic [CTL_W-1:0]   ctl_true;
  logic [N_LATCH-1:0] latch_lvl;
  logic [N_LATCH-1:0] clr_req;
  logic [N_LATCH-1:0] fall_evt;
  logic [N_LATCH-1:0] hold_q;
  logic               cin_wr;

  port_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .dout_q(dout_q), .cout_q(cout_q)
  );

  pin_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_dsync (
    .clk(clk), .rst_n(rst_n), .pin_raw(data_pin), .pin_lvl(data_lvl)
  );

  pin_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_csync (
    .clk(clk), .rst_n(rst_n), .pin_raw(ctl_pin), .pin_lvl(ctl_lvl)
  );

  assign cin_wr    = reg_wr && (reg_addr == A_CIN);
  assign clr_req   = {cin_wr & reg_wdata[B_SVCREQ], cin_wr & reg_wdata[B_ATTN]};
  assign latch_lvl = {ctl_lvl[B_SVCREQ], ctl_lvl[B_ATTN]};

  fall_latch #(.W(N_LATCH)) u_latch (
    .clk(clk), .rst_n(rst_n), .lvl(latch_lvl), .clr(clr_req),
    .fall_evt(fall_evt), .hold_q(hold_q)
  );

  assign ctl_true = ctl_asserted(ctl_lvl);

  // pin drive: register bits plus the two hard-wired lines
  always_comb begin
    ctl_pull            = cout_q;
    ctl_pull[B_IFCLR]   = ~rst_n;
    ctl_pull[B_REMOTE]  = 1'b1;
  end
  assign data_pull = dout_q;
  assign blank_out = cout_q[B_ENDMSG];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_DOUT: reg_rdata[DW_RD-1:0] = dout_q[DW_RD-1:0];
      A_COUT: reg_rdata = cout_q;
      A_DIN:  reg_rdata[DW_RD-1:0] = ~data_lvl[DW_RD-1:0];
      default: begin
        reg_rdata           = ctl_true & LEVEL_MASK;
        reg_rdata[B_ATTN]   = hold_q[0];
        reg_rdata[B_SVCREQ] = hold_q[1];
      end
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{ctl_true[B_IFCLR], ctl_true[B_REMOTE], ctl_true[B_ATTN],
                         ctl_true[B_SVCREQ], dout_q, data_lvl};
endmodule

// File: rtl/gpib_port_regs_chk.sv
module gpib_port_regs_chk
  import gpib_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] data_pull,
  input logic [CTL_W-1:0]  ctl_pull,
  input logic              blank_out,
  input logic [N_LATCH-1:0] fall_evt,
  input logic [N_LATCH-1:0] hold_q,
  input logic [N_LATCH-1:0] clr_req
);
  assert_data_pull_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(data_pull) |-> $past(reg_wr && reg_addr == A_DOUT));

  assert_ctl_pull_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ctl_pull & COUT_WMASK) |-> $past(reg_wr && reg_addr == A_COUT));

  assert_blank_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(blank_out) |-> $past(reg_wr && reg_addr == A_COUT));

  for (genvar k = 0; k < N_LATCH; k++) begin : g_lat
    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q[k] && !clr_req[k]) |=> hold_q[k]);

    assert_latch_set_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_q[k]) |-> $past(fall_evt[k]));

    assert_latch_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req[k] && !fall_evt[k]) |=> !hold_q[k]);

    assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt[k] |=> hold_q[k]);
  end
endmodule

bind gpib_port_regs gpib_port_regs_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .data_pull(data_pull), .ctl_pull(ctl_pull), .blank_out(blank_out),
  .fall_evt(fall_evt), .hold_q(hold_q), .clr_req(clr_req)
);

// File: tb/gpib_port_regs_tb.sv
module gpib_port_regs_tb_top;
  typedef enum int {K_RD, K_DPULL, K_CPULL, K_BLANK} kind_e;
  typedef struct {
    kind_e       kind;
    logic [7:0]  exp;
    string       tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] data_pull, ctl_pull, data_pin, ctl_pin;
  logic [7:0] ext_data = '0, ext_ctl = '0;
  logic       blank_out;

  item_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  // open-collector bus model: low if anyone pulls
  assign data_pin = ~(data_pull | ext_data);
  assign ctl_pin  = ~(ctl_pull | ext_ctl);

  gpib_port_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_pin(data_pin),
    .data_pull(data_pull), .ctl_pin(ctl_pin), .ctl_pull(ctl_pull),
    .blank_out(blank_out)
  );

  // monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    #5;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = reg_rdata;
        K_DPULL: act = data_pull;
        K_CPULL: act = ctl_pull;
        default: act = {7'd0, blank_out};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb_q.push_back('{K_RD, e, tag});
  endtask

  task automatic exp_out(input kind_e k, input logic [7:0] e, input string tag);
    @(negedge clk);
    sb_q.push_back('{k, e, tag});
  endtask

  initial begin
    cyc(3);
    exp_out(K_CPULL, 8'h60, "R10 lines pulled in reset");
    exp_out(K_DPULL, 8'h00, "R1 data released in reset");
    cyc(1);
    rst_n = 1'b1;
    cyc(4);
    exp_out(K_CPULL, 8'h40, "R10 only remote pulled after reset");
    exp_out(K_BLANK, 8'h00, "R1 blank low");
    exp_rd(2'd0, 8'h00, "R1 data out reg");
    exp_rd(2'd1, 8'h00, "R1 control out reg");
    exp_rd(2'd3, 8'h00, "R1 latches clear, R5 bits 5/6 read 0");

    // R2 / R4 own drive
    wr(2'd0, 8'hA5);
    exp_out(K_DPULL, 8'hA5, "R2 data pull");
    exp_rd(2'd0, 8'hA5, "R2 data out readback");
    cyc(2);
    exp_rd(2'd2, 8'hA5, "R4 own drive read back");
    // R4 external and overlapping
    ext_data = 8'h0F;
    cyc(3);
    exp_rd(2'd2, 8'hAF, "R4 own plus external");
    wr(2'd0, 8'h00);
    cyc(3);
    exp_rd(2'd2, 8'h0F, "R4 external only");
    ext_data = 8'h00;
    cyc(3);
    exp_rd(2'd2, 8'h00, "R4 released");

    // R3 / R7 / R9 / R5
    wr(2'd1, 8'hFF);
    exp_rd(2'd1, 8'h8F, "R3 writable mask");
    exp_out(K_CPULL, 8'hCF, "R3 control pull");
    exp_out(K_BLANK, 8'h01, "R9 blank from end bit");
    cyc(4);
    exp_rd(2'd3, 8'h8F, "R7 own attention sets latch, R5 levels");
    wr(2'd3, 8'h00);
    exp_rd(2'd3, 8'h8F, "R6 zero write keeps latch");
    wr(2'd3, 8'h08);
    exp_rd(2'd3, 8'h87, "R6 clear with line held");
    wr(2'd1, 8'h00);
    exp_out(K_BLANK, 8'h00, "R9 blank off");
    cyc(4);
    exp_rd(2'd3, 8'h00, "R5 levels released");

    // R9 external end-of-message
    ext_ctl = 8'h80;
    cyc(3);
    exp_rd(2'd3, 8'h80, "R5 external end level");
    exp_out(K_BLANK, 8'h00, "R9 external end does not blank");
    ext_ctl = 8'h00;

    // R6 service request
    cyc(3);
    ext_ctl = 8'h10;
    cyc(4);
    exp_rd(2'd3, 8'h10, "R6 service request captured");
    ext_ctl = 8'h00;
    cyc(4);
    exp_rd(2'd3, 8'h10, "R6 service request held after release");
    wr(2'd3, 8'h10);
    exp_rd(2'd3, 8'h00, "R6 service request cleared");

    // R8 clear coincides with fresh edge
    ext_ctl = 8'h08;
    cyc(4);
    exp_rd(2'd3, 8'h08, "R6 external attention captured");
    ext_ctl = 8'h00;
    cyc(4);
    @(negedge clk);
    ext_ctl = 8'h08;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 2'd3; reg_wdata = 8'h08; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    exp_rd(2'd3, 8'h08, "R8 edge wins over clear");
    wr(2'd3, 8'h08);
    exp_rd(2'd3, 8'h00, "R6 later clear works");
    ext_ctl = 8'h00;
    cyc(3);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    end
    @(negedge clk);
    #6;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule